// File: doc/BRIEF.md
# Rename-Stage Load/Store Credit Gate

This block sits between decode and dispatch in an out-of-order core. Each cycle it sees an in-order group of up to `W` instructions and decides how many of them, counted from slot 0, may be renamed and sent on. Reorder-buffer and issue-queue room come from free-entry reports sent back by the later stages. Load-queue room and store-queue room are tracked as two separate credits, so running out of one never holds back instructions that need only the other.

Each queue credit is the last free count reported for that queue, minus the instructions of that kind that were renamed but not yet dispatched. Two signed in-flight counters keep that number. A counter rises for every accepted load (or store) and falls by the count that dispatch reports for the cycle. That count includes entries drained from the dispatch skid buffer during a flush. The reported queue counts already leave out the one spare slot that each circular queue holds back to tell empty from full, so after reset they start at depth minus one.

The stall logic is a small state machine whose state is the previous cycle's stall cause. It has five states: `CZ_NONE`, `CZ_ROB`, `CZ_IQ`, `CZ_LQ` and `CZ_SQ`. Every cycle it moves to the cause decided in that cycle. Any state may move to any other, and a state may also stay where it is. An event counter for a cause increases on each transition into that cause from a different state.

Top module: `rename_credit_gate`

## Requirements
- R1: After reset, `lq_room` is LQ_DEPTH-1, `sq_room` is SQ_DEPTH-1, ROB and IQ room equal their depths, both in-flight counters are zero, every event counter is zero and `stall_cause` is 0.
- R2: `lq_room` equals the effective free LQ count minus (loads in flight minus `ld_disp_cnt`), in signed arithmetic. The effective count is `lq_rpt_free` in a cycle where `lsq_rpt_vld` is 1, and otherwise the cached count. `sq_room` is computed the same way from the store-side values.
- R3: At each clock edge, the load in-flight counter gains the number of loads accepted and loses `ld_disp_cnt`. The store counter behaves the same way, and neither counter ever drops below zero.
- R4: The cached LQ and SQ free counts are replaced together, and only at an edge where `lsq_rpt_vld` is 1. Report values presented without the valid flag have no effect. The same holds for ROB and IQ with their own valid flags.
- R5: Each accepted instruction uses one ROB credit and one IQ credit. A slot is refused when either remaining credit is zero or less. The cause is ROB (1) if remaining ROB credit is less than or equal to remaining IQ credit, and IQ (2) otherwise. This check comes before any queue check.
- R6: A load (`slot_ld`) needs LQ room above zero after the loads accepted earlier in the same group, or it is refused with cause LQ (3). A store (`slot_st`) needs SQ room in the same way, or it is refused with cause SQ (4). An instruction that is neither ignores both queue credits.
- R7: A store queue with no room does not block loads, and a load queue with no room does not block stores.
- R8: Slots are judged in order from slot 0. Once a slot is refused, no later slot is accepted in that cycle, and `accept_cnt` is the number of accepted slots before it.
- R9: The first slot with `slot_vld` at 0 ends the group with no stall. Valid slots after a gap are not accepted.
- R10: `stall_cause` uses 0=NONE, 1=ROB, 2=IQ, 3=LQ, 4=SQ. `stall` is 1 exactly when `stall_cause` is not 0.
- R11: The event counter of a cause increases by one at the edge that ends a cycle stalled on that cause, when the previous cycle's cause was different. A stall that continues with the same cause does not count again.
- R12: `lsq_dry` is 1 exactly when `lq_room` and `sq_room` are both zero or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | W | Slot holds an instruction (bit 0 is oldest) |
| slot_ld | input | W | Slot is a load |
| slot_st | input | W | Slot is a store |
| rob_rpt_vld | input | 1 | ROB free report valid this cycle |
| rob_rpt_free | input | RW | Reported free ROB entries |
| iq_rpt_vld | input | 1 | IQ free report valid this cycle |
| iq_rpt_free | input | RW | Reported free IQ entries |
| lsq_rpt_vld | input | 1 | LQ and SQ free reports valid this cycle |
| lq_rpt_free | input | RW | Reported free LQ entries (spare slot excluded) |
| sq_rpt_free | input | RW | Reported free SQ entries (spare slot excluded) |
| ld_disp_cnt | input | RW | Loads dispatched or drained downstream this cycle |
| st_disp_cnt | input | RW | Stores dispatched or drained downstream this cycle |
| accept_cnt | output | AW | Instructions accepted from slot 0 upward |
| stall | output | 1 | A valid slot was refused |
| stall_cause | output | 3 | Stall cause code |
| lsq_dry | output | 1 | Both queue credits exhausted |
| lq_room | output | RW+2 signed | Current load-queue credit |
| sq_room | output | RW+2 signed | Current store-queue credit |
| ev_rob_cnt | output | EVW | ROB stall events |
| ev_iq_cnt | output | EVW | IQ stall events |
| ev_lq_cnt | output | EVW | LQ stall events |
| ev_sq_cnt | output | EVW | SQ stall events |

## Verification
`accept_cnt`, `stall`, `stall_cause`, `lsq_dry` and both room outputs are combinational in the present inputs and registered state, so they are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and compares these outputs 1 ns later, before the rising edge commits them. The in-flight counters, the cached reports and the event counters change at the rising edge. Their effect is checked one cycle later, through the room outputs or the counter ports, after the next falling edge.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    typedef enum logic [2:0] {
        CZ_NONE = 3'd0,
        CZ_ROB  = 3'd1,
        CZ_IQ   = 3'd2,
        CZ_LQ   = 3'd3,
        CZ_SQ   = 3'd4
    } stall_cz_e;

    localparam int NUM_CAUSES = 4;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rcg_free_reg.sv
// Cached free-entry count; a valid report is used in its own cycle and latched.
module rcg_free_reg #(
    parameter int RW       = 6,
    parameter int RST_FREE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rpt_vld,
    input  logic [RW-1:0] rpt_free,
    output logic [RW-1:0] free_eff,
    output logic [RW-1:0] cached
);

    logic [RW-1:0] cache_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cache_q <= RW'(RST_FREE);
        else if (rpt_vld)
            cache_q <= rpt_free;
    end

    assign free_eff = rpt_vld ? rpt_free : cache_q;
    assign cached   = cache_q;

endmodule

// File: rtl/rcg_queue_credit.sv
// Queue credit: cached free count minus instructions renamed but not dispatched.
module rcg_queue_credit #(
    parameter int RW       = 6,
    parameter int AW       = 3,
    parameter int RST_FREE = 7,
    localparam int CW      = RW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rpt_vld,
    input  logic [RW-1:0]        rpt_free,
    input  logic [RW-1:0]        disp_cnt,
    input  logic [AW-1:0]        take_cnt,
    output logic signed [CW-1:0] room,
    output logic signed [CW-1:0] inflight,
    output logic [RW-1:0]        cached
);

    logic [RW-1:0]        free_eff;
    logic signed [CW-1:0] infl_q;
    logic signed [CW-1:0] free_s;
    logic signed [CW-1:0] disp_s;
    logic signed [CW-1:0] take_s;

    rcg_free_reg #(.RW(RW), .RST_FREE(RST_FREE)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .rpt_vld  (rpt_vld),
        .rpt_free (rpt_free),
        .free_eff (free_eff),
        .cached   (cached)
    );

    assign free_s = $signed({2'b00, free_eff});
    assign disp_s = $signed({2'b00, disp_cnt});
    assign take_s = $signed({{(CW-AW){1'b0}}, take_cnt});

    always_ff @(posedge clk) begin
        if (!rst_n)
            infl_q <= '0;
        else
            infl_q <= infl_q - disp_s + take_s;
    end

    assign room     = free_s - (infl_q - disp_s);
    assign inflight = infl_q;

endmodule

// File: rtl/rcg_slot_scan.sv
// In-order judgement of the group against ROB, IQ, LQ and SQ credit.
module rcg_slot_scan
    import rcg_pkg::*;
#(
    parameter int W  = 4,
    parameter int RW = 6,
    parameter int AW = 3,
    localparam int CW = RW + 2
) (
    input  logic [W-1:0]         slot_vld,
    input  logic [W-1:0]         slot_ld,
    input  logic [W-1:0]         slot_st,
    input  logic signed [CW-1:0] rob_room,
    input  logic signed [CW-1:0] iq_room,
    input  logic signed [CW-1:0] lq_room,
    input  logic signed [CW-1:0] sq_room,
    output logic [AW-1:0]        acc_cnt,
    output logic [AW-1:0]        ld_take,
    output logic [AW-1:0]        st_take,
    output stall_cz_e            cause
);

    always_comb begin
        logic                 open;
        logic signed [CW-1:0] rl;
        logic signed [CW-1:0] il;
        logic signed [CW-1:0] ll;
        logic signed [CW-1:0] sl;
        open    = 1'b1;
        rl      = rob_room;
        il      = iq_room;
        ll      = lq_room;
        sl      = sq_room;
        acc_cnt = '0;
        ld_take = '0;
        st_take = '0;
        cause   = CZ_NONE;
        for (int i = 0; i < W; i++) begin
            if (open) begin
                if (!slot_vld[i]) begin
                    open = 1'b0;
                end else if (rl <= 0 || il <= 0) begin
                    open  = 1'b0;
                    cause = (rl <= il) ? CZ_ROB : CZ_IQ;
                end else if (slot_ld[i] && ll <= 0) begin
                    open  = 1'b0;
                    cause = CZ_LQ;
                end else if (slot_st[i] && sl <= 0) begin
                    open  = 1'b0;
                    cause = CZ_SQ;
                end else begin
                    acc_cnt = acc_cnt + AW'(1);
                    rl      = rl - CW'(1);
                    il      = il - CW'(1);
                    if (slot_ld[i]) begin
                        ll      = ll - CW'(1);
                        ld_take = ld_take + AW'(1);
                    end
                    if (slot_st[i]) begin
                        sl      = sl - CW'(1);
                        st_take = st_take + AW'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rcg_stall_fsm.sv
// State is the previous cycle's stall cause; entering a cause counts an event.
module rcg_stall_fsm
    import rcg_pkg::*;
#(
    parameter int EVW = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  stall_cz_e                         cur_cause,
    output stall_cz_e                         prev_cause,
    output logic [NUM_CAUSES-1:0][EVW-1:0]    ev_cnt
);

    stall_cz_e             state_q;
    logic [NUM_CAUSES-1:0] bump;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= CZ_NONE;
        else
            state_q <= cur_cause;
    end

    always_comb begin
        bump = '0;
        if (cur_cause != state_q) begin
            unique case (cur_cause)
                CZ_ROB:  bump[0] = 1'b1;
                CZ_IQ:   bump[1] = 1'b1;
                CZ_LQ:   bump[2] = 1'b1;
                CZ_SQ:   bump[3] = 1'b1;
                CZ_NONE: bump    = '0;
                default: bump    = '0;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_CAUSES; k++) begin : g_ev
        logic [EVW-1:0] ev_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ev_q <= '0;
            else if (bump[k])
                ev_q <= ev_q + EVW'(1);
        end
        assign ev_cnt[k] = ev_q;
    end

    assign prev_cause = state_q;

endmodule

// File: rtl/rename_credit_gate.sv
module rename_credit_gate
    import rcg_pkg::*;
#(
    parameter int W         = 4,
    parameter int LQ_DEPTH  = 8,
    parameter int SQ_DEPTH  = 8,
    parameter int ROB_DEPTH = 32,
    parameter int IQ_DEPTH  = 16,
    parameter int EVW       = 16,
    localparam int MAXD     = max_of4(LQ_DEPTH, SQ_DEPTH, ROB_DEPTH, IQ_DEPTH),
    localparam int RW       = $clog2(MAXD + 1),
    localparam int CW       = RW + 2,
    localparam int AW       = $clog2(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         slot_vld,
    input  logic [W-1:0]         slot_ld,
    input  logic [W-1:0]         slot_st,
    input  logic                 rob_rpt_vld,
    input  logic [RW-1:0]        rob_rpt_free,
    input  logic                 iq_rpt_vld,
    input  logic [RW-1:0]        iq_rpt_free,
    input  logic                 lsq_rpt_vld,
    input  logic [RW-1:0]        lq_rpt_free,
    input  logic [RW-1:0]        sq_rpt_free,
    input  logic [RW-1:0]        ld_disp_cnt,
    input  logic [RW-1:0]        st_disp_cnt,
    output logic [AW-1:0]        accept_cnt,
    output logic                 stall,
    output logic [2:0]           stall_cause,
    output logic                 lsq_dry,
    output logic signed [CW-1:0] lq_room,
    output logic signed [CW-1:0] sq_room,
    output logic [EVW-1:0]       ev_rob_cnt,
    output logic [EVW-1:0]       ev_iq_cnt,
    output logic [EVW-1:0]       ev_lq_cnt,
    output logic [EVW-1:0]       ev_sq_cnt
);

    // index 0 = load queue, index 1 = store queue
    logic [RW-1:0]        q_rpt    [2];
    logic [RW-1:0]        q_disp   [2];
    logic [AW-1:0]        q_take   [2];
    logic signed [CW-1:0] q_room   [2];
    logic signed [CW-1:0] q_infl   [2];
    logic [RW-1:0]        q_cached [2];

    logic [RW-1:0]        rob_eff, iq_eff, rob_cached, iq_cached;
    logic signed [CW-1:0] rob_room, iq_room;
    stall_cz_e            cur_cause, prev_cause;
    logic [NUM_CAUSES-1:0][EVW-1:0] ev_cnt;

    assign q_rpt[0]  = lq_rpt_free;
    assign q_rpt[1]  = sq_rpt_free;
    assign q_disp[0] = ld_disp_cnt;
    assign q_disp[1] = st_disp_cnt;

    for (genvar q = 0; q < 2; q++) begin : g_q
        rcg_queue_credit #(
            .RW       (RW),
            .AW       (AW),
            .RST_FREE ((q == 0) ? LQ_DEPTH - 1 : SQ_DEPTH - 1)
        ) u_credit (
            .clk      (clk),
            .rst_n    (rst_n),
            .rpt_vld  (lsq_rpt_vld),
            .rpt_free (q_rpt[q]),
            .disp_cnt (q_disp[q]),
            .take_cnt (q_take[q]),
            .room     (q_room[q]),
            .inflight (q_infl[q]),
            .cached   (q_cached[q])
        );
    end

    rcg_free_reg #(.RW(RW), .RST_FREE(ROB_DEPTH)) u_rob (
        .clk      (clk),
        .rst_n    (rst_n),
        .rpt_vld  (rob_rpt_vld),
        .rpt_free (rob_rpt_free),
        .free_eff (rob_eff),
        .cached   (rob_cached)
    );

    rcg_free_reg #(.RW(RW), .RST_FREE(IQ_DEPTH)) u_iq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rpt_vld  (iq_rpt_vld),
        .rpt_free (iq_rpt_free),
        .free_eff (iq_eff),
        .cached   (iq_cached)
    );

    assign rob_room = $signed({2'b00, rob_eff});
    assign iq_room  = $signed({2'b00, iq_eff});

    rcg_slot_scan #(.W(W), .RW(RW), .AW(AW)) u_scan (
        .slot_vld (slot_vld),
        .slot_ld  (slot_ld),
        .slot_st  (slot_st),
        .rob_room (rob_room),
        .iq_room  (iq_room),
        .lq_room  (q_room[0]),
        .sq_room  (q_room[1]),
        .acc_cnt  (accept_cnt),
        .ld_take  (q_take[0]),
        .st_take  (q_take[1]),
        .cause    (cur_cause)
    );

    rcg_stall_fsm #(.EVW(EVW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_cause  (cur_cause),
        .prev_cause (prev_cause),
        .ev_cnt     (ev_cnt)
    );

    assign stall       = (cur_cause != CZ_NONE);
    assign stall_cause = cur_cause;
    assign lq_room     = q_room[0];
    assign sq_room     = q_room[1];
    assign lsq_dry     = (q_room[0] <= 0) && (q_room[1] <= 0);
    assign ev_rob_cnt  = ev_cnt[0];
    assign ev_iq_cnt   = ev_cnt[1];
    assign ev_lq_cnt   = ev_cnt[2];
    assign ev_sq_cnt   = ev_cnt[3];

endmodule

// File: rtl/rcg_checker.sv
module rcg_checker
    import rcg_pkg::*;
#(
    parameter int W         = 4,
    parameter int LQ_DEPTH  = 8,
    parameter int SQ_DEPTH  = 8,
    parameter int ROB_DEPTH = 32,
    parameter int IQ_DEPTH  = 16,
    parameter int EVW       = 16,
    localparam int MAXD     = max_of4(LQ_DEPTH, SQ_DEPTH, ROB_DEPTH, IQ_DEPTH),
    localparam int RW       = $clog2(MAXD + 1),
    localparam int CW       = RW + 2,
    localparam int AW       = $clog2(W + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lsq_rpt_vld,
    input logic signed [CW-1:0] ld_infl,
    input logic signed [CW-1:0] st_infl,
    input logic [RW-1:0]        lq_cached,
    input logic [RW-1:0]        sq_cached,
    input logic signed [CW-1:0] lq_room,
    input logic signed [CW-1:0] rob_room,
    input logic signed [CW-1:0] iq_room,
    input logic [AW-1:0]        ld_take,
    input logic [AW-1:0]        accept_cnt,
    input stall_cz_e            cur_cause,
    input stall_cz_e            prev_cause,
    input logic [EVW-1:0]       ev_sq_cnt
);

    assert_infl_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_infl >= 0) && (st_infl >= 0));

    assert_cache_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lsq_rpt_vld |=> (lq_cached == $past(lq_cached)) && (sq_cached == $past(sq_cached)));

    assert_no_load_without_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_room <= 0) |-> (ld_take == '0));

    assert_robiq_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rob_room <= 0) || (iq_room <= 0)) |-> (accept_cnt == '0));

    assert_sq_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_cause == CZ_SQ) && (prev_cause != CZ_SQ)) |=> (ev_sq_cnt == $past(ev_sq_cnt) + EVW'(1)));

endmodule

bind rename_credit_gate rcg_checker #(
    .W(W), .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH),
    .ROB_DEPTH(ROB_DEPTH), .IQ_DEPTH(IQ_DEPTH), .EVW(EVW)
) u_rcg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lsq_rpt_vld (lsq_rpt_vld),
    .ld_infl     (q_infl[0]),
    .st_infl     (q_infl[1]),
    .lq_cached   (q_cached[0]),
    .sq_cached   (q_cached[1]),
    .lq_room     (lq_room),
    .rob_room    (rob_room),
    .iq_room     (iq_room),
    .ld_take     (q_take[0]),
    .accept_cnt  (accept_cnt),
    .cur_cause   (cur_cause),
    .prev_cause  (prev_cause),
    .ev_sq_cnt   (ev_sq_cnt)
);

// File: tb/rename_credit_gate_bench.sv
`timescale 1ns/1ps
module rename_credit_gate_bench;

    localparam int W = 4, RW = 6, CW = 8, AW = 3, EVW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] slot_vld = '0, slot_ld = '0, slot_st = '0;
    logic rob_rpt_vld = 1'b0, iq_rpt_vld = 1'b0, lsq_rpt_vld = 1'b0;
    logic [RW-1:0] rob_rpt_free = '0, iq_rpt_free = '0, lq_rpt_free = '0, sq_rpt_free = '0;
    logic [RW-1:0] ld_disp_cnt = '0, st_disp_cnt = '0;
    logic [AW-1:0] accept_cnt;
    logic stall, lsq_dry;
    logic [2:0] stall_cause;
    logic signed [CW-1:0] lq_room, sq_room;
    logic [EVW-1:0] ev_rob_cnt, ev_iq_cnt, ev_lq_cnt, ev_sq_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rename_credit_gate u_rename_credit_gate (
        .clk(clk), .rst_n(rst_n),
        .slot_vld(slot_vld), .slot_ld(slot_ld), .slot_st(slot_st),
        .rob_rpt_vld(rob_rpt_vld), .rob_rpt_free(rob_rpt_free),
        .iq_rpt_vld(iq_rpt_vld), .iq_rpt_free(iq_rpt_free),
        .lsq_rpt_vld(lsq_rpt_vld), .lq_rpt_free(lq_rpt_free), .sq_rpt_free(sq_rpt_free),
        .ld_disp_cnt(ld_disp_cnt), .st_disp_cnt(st_disp_cnt),
        .accept_cnt(accept_cnt), .stall(stall), .stall_cause(stall_cause),
        .lsq_dry(lsq_dry), .lq_room(lq_room), .sq_room(sq_room),
        .ev_rob_cnt(ev_rob_cnt), .ev_iq_cnt(ev_iq_cnt),
        .ev_lq_cnt(ev_lq_cnt), .ev_sq_cnt(ev_sq_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive a group at the falling edge, let combinational outputs settle
    task automatic apply(input logic [W-1:0] v, input logic [W-1:0] l, input logic [W-1:0] s);
        slot_vld = v; slot_ld = l; slot_st = s;
        #1;
    endtask

    // check the decision, then commit it at the rising edge and clear pulses
    task automatic commit(input int e_acc, input int e_cz, input string tag);
        chk({tag, " accept"}, int'(accept_cnt), e_acc);
        chk({tag, " cause R10"}, int'(stall_cause), e_cz);
        chk({tag, " stall R10"}, int'(stall), (e_cz != 0) ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        slot_vld = '0; slot_ld = '0; slot_st = '0;
        rob_rpt_vld = 1'b0; iq_rpt_vld = 1'b0; lsq_rpt_vld = 1'b0;
        ld_disp_cnt = '0; st_disp_cnt = '0;
    endtask

    task automatic t_reset;
        apply('0, '0, '0);
        chk("R1 lq_room", int'(lq_room), 7);
        chk("R1 sq_room", int'(sq_room), 7);
        chk("R1 ev_rob", int'(ev_rob_cnt), 0);
        chk("R1 ev_sq", int'(ev_sq_cnt), 0);
        chk("R12 dry at reset", int'(lsq_dry), 0);
        commit(0, 0, "R1 idle");
        apply(4'b1111, 4'b0000, 4'b0000);
        commit(4, 0, "R5 alu group full room");
    endtask

    task automatic t_split;
        apply(4'b1111, 4'b0000, 4'b1111);
        commit(4, 0, "R6 four stores");
        apply(4'b1111, 4'b0000, 4'b1111);
        chk("R3 sq_room after 4 stores", int'(sq_room), 3);
        commit(3, 4, "R6 store limit");
        apply(4'b1111, 4'b1111, 4'b0000);
        chk("R11 sq event after begin", int'(ev_sq_cnt), 1);
        chk("R7 lq_room with SQ full", int'(lq_room), 7);
        commit(4, 0, "R7 loads pass full SQ");
        apply(4'b0011, 4'b0011, 4'b0000);
        commit(2, 0, "R6 loads within room");
        apply(4'b0011, 4'b0001, 4'b0010);
        chk("R6 lq_room one left", int'(lq_room), 1);
        commit(1, 4, "R8 store refused after load");
        apply(4'b0011, 4'b0011, 4'b0000);
        chk("R11 sq event second begin", int'(ev_sq_cnt), 2);
        chk("R12 both dry", int'(lsq_dry), 1);
        commit(0, 3, "R6 load refused LQ");
        apply(4'b1111, 4'b0000, 4'b0000);
        chk("R11 lq event", int'(ev_lq_cnt), 1);
        commit(4, 0, "R6 non-memory ignores queues");
        ld_disp_cnt = 6'd2;
        apply(4'b0011, 4'b0010, 4'b0001);
        chk("R2 dispatch returns credit", int'(lq_room), 2);
        commit(0, 4, "R8 store at head blocks load");
        lsq_rpt_vld = 1'b1; lq_rpt_free = 6'd0; sq_rpt_free = 6'd0;
        ld_disp_cnt = 6'd5; st_disp_cnt = 6'd7;
        apply('0, '0, '0);
        chk("R2 report plus dispatch lq", int'(lq_room), 0);
        chk("R2 report plus dispatch sq", int'(sq_room), 0);
        commit(0, 0, "R9 empty group");
        lsq_rpt_vld = 1'b1; lq_rpt_free = 6'd5; sq_rpt_free = 6'd3;
        apply('0, '0, '0);
        chk("R3 lq counter drained", int'(lq_room), 5);
        chk("R3 sq counter drained", int'(sq_room), 3);
        commit(0, 0, "R4 load report");
        lq_rpt_free = 6'd9; sq_rpt_free = 6'd9;
        apply('0, '0, '0);
        chk("R4 invalid report lq", int'(lq_room), 5);
        chk("R4 invalid report sq", int'(sq_room), 3);
        chk("R12 not dry", int'(lsq_dry), 0);
        commit(0, 0, "R4 ignored report");
        apply(4'b1111, 4'b0000, 4'b1111);
        commit(3, 4, "R6 store room three");
        lsq_rpt_vld = 1'b1; lq_rpt_free = 6'd5; sq_rpt_free = 6'd0; st_disp_cnt = 6'd3;
        apply('0, '0, '0);
        chk("R2 sq report with dispatch", int'(sq_room), 0);
        chk("R11 sq event third", int'(ev_sq_cnt), 4);
        commit(0, 0, "R2 idle");
    endtask

    task automatic t_robiq;
        rob_rpt_vld = 1'b1; rob_rpt_free = 6'd2;
        apply(4'b1111, 4'b0000, 4'b0000);
        commit(2, 1, "R5 ROB limits group");
        apply(4'b0001, 4'b0001, 4'b0000);
        chk("R11 rob event", int'(ev_rob_cnt), 1);
        commit(1, 0, "R4 cached ROB room");
        rob_rpt_vld = 1'b1; rob_rpt_free = 6'd0;
        apply(4'b0001, 4'b0001, 4'b0000);
        commit(0, 1, "R5 ROB empty blocks group");
        rob_rpt_vld = 1'b1; rob_rpt_free = 6'd10; iq_rpt_vld = 1'b1; iq_rpt_free = 6'd0;
        apply(4'b0011, 4'b0000, 4'b0000);
        commit(0, 2, "R5 IQ empty");
        rob_rpt_vld = 1'b1; rob_rpt_free = 6'd1; iq_rpt_vld = 1'b1; iq_rpt_free = 6'd1;
        apply(4'b1111, 4'b0000, 4'b0000);
        chk("R11 iq event", int'(ev_iq_cnt), 1);
        commit(1, 1, "R5 tie picks ROB");
        rob_rpt_vld = 1'b1; rob_rpt_free = 6'd0;
        apply(4'b0001, 4'b0000, 4'b0001);
        commit(0, 1, "R5 ROB before SQ");
        rob_rpt_vld = 1'b1; rob_rpt_free = 6'd32; iq_rpt_vld = 1'b1; iq_rpt_free = 6'd16;
        apply(4'b0101, 4'b0000, 4'b0000);
        chk("R11 rob continuing stall", int'(ev_rob_cnt), 3);
        commit(1, 0, "R9 gap ends group");
    endtask

    task automatic t_order;
        apply(4'b0111, 4'b0101, 4'b0010);
        chk("R2 lq_room in order test", int'(lq_room), 4);
        commit(1, 4, "R8 later load not taken");
        apply('0, '0, '0);
        chk("R11 final rob", int'(ev_rob_cnt), 3);
        chk("R11 final iq", int'(ev_iq_cnt), 1);
        chk("R11 final lq", int'(ev_lq_cnt), 1);
        chk("R11 final sq", int'(ev_sq_cnt), 5);
        chk("R3 lq_room after order", int'(lq_room), 3);
        commit(0, 0, "R9 idle end");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_split();
        t_robiq();
        t_order();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule